// File: doc/BRIEF.md
# Triggered Single-Channel DMA Engine

This block is one channel of a direct memory access engine. It copies a block of 16-bit or 32-bit units from a source region to a target region through a simple bus master port, one bus operation per clock. The port carries a read strobe, a write strobe, an idle strobe, an access size and a sequential hint. Memory is assumed to answer in the same cycle: read data is taken in the cycle of the read strobe.

Software places the source, the target, the unit count, the stepping controls, the size, the repeat flag, the trigger mode and the interrupt flags on the configuration inputs. It then writes the enable bit. A 0 to 1 write of enable copies source, target and count into working registers. The channel then either starts at once or waits for a frame-blank, line-blank or line-request pulse. After a short start delay it moves the block and steps its working addresses. It does not touch the protected low region, and it charges two idle cycles at the start of a block unless both ends lie in cartridge space. At the end of the block it either reloads for the next trigger or clears its own enable, and it raises single-clock interrupt pulses.

Addresses are 28 bits wide by default, so that the cartridge-space bit (bit 27, the top bit) exists. The count is 14 bits wide. A programmed count of 0 wraps, so the block is 2^14 units long.

Top module: `dma_channel`

## Requirements
- R1: With `cfg_word`=1 each unit is a 32-bit access and the working addresses step by 4. With `cfg_word`=0 each unit is a 16-bit access and they step by 2. `bus_word` reports the size.
- R2: `bus_addr` on a read or write has bits [1:0] cleared for word units and bit 0 cleared for halfword units.
- R3: Source control `cfg_src_ctl`: 0 increments the working source after each unit, 1 decrements it, 2 and 3 hold it.
- R4: Target control `cfg_dst_ctl`: 0 increments, 1 decrements and 2 holds. 3 increments during the block, and at the end of the block the working target is set back to `cfg_dst`.
- R5: Read and write of the first unit of a block (working count equal to `cfg_count`) carry `bus_seq`=0. Every later unit carries `bus_seq`=1. Idle cycles carry `bus_seq`=0.
- R6: On the first unit, unless both working source and working target have bit 27 set, two idle cycles (`bus_idle`) come before the unit's read slot. When both have it set, the read comes first.
- R7: A working source below 0x0200_0000 gives an idle cycle instead of the read. A working target below that bound gives an idle cycle instead of the write. The write data is always the last unit actually read.
- R8: After activation a start counter of 2 counts down once per clock. The first bus operation appears in the third clock after the edge that samples the trigger, and operations then follow on every clock.
- R9: While `cpu_halt`=1 no new unit starts. The start counter still runs. Units resume on the clock `cpu_halt` falls.
- R10: Trigger mode `cfg_timing`: 0 activates on the enable 0→1 write. 1 activates on `vblank_pulse`, 2 on `hblank_pulse` and 3 on `line_req_pulse`. Mode 3 works only when the parameter CHAN_ID is 3. Pulses of other kinds are ignored.
- R11: When the working count reaches zero the channel goes inactive. With `cfg_repeat`=1 the count is reloaded and `chan_enabled` stays 1. With `cfg_repeat`=0 `chan_enabled` falls to 0.
- R12: At block end, with `cfg_irq_en`=1, `irq_vec` pulses bit CHAN_ID for one clock. With `cfg_req`=1 and CHAN_ID=3, `cart_irq` pulses for one clock. No other `irq_vec` bit ever rises.
- R13: Source, target and count are latched on the enable 0→1 write. Later changes to `cfg_src` or `cfg_dst` do not alter the block's addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cpu_halt | input | 1 | Processor stopped; blocks new units |
| vblank_pulse | input | 1 | Frame-blank trigger |
| hblank_pulse | input | 1 | Line-blank trigger |
| line_req_pulse | input | 1 | Special per-line request trigger |
| cfg_src | input | ADDR_W | Programmed source address |
| cfg_dst | input | ADDR_W | Programmed target address |
| cfg_count | input | CNT_W | Programmed unit count |
| cfg_src_ctl | input | 2 | Source stepping control |
| cfg_dst_ctl | input | 2 | Target stepping control |
| cfg_word | input | 1 | 1 = 32-bit units, 0 = 16-bit units |
| cfg_repeat | input | 1 | Reload and stay enabled at block end |
| cfg_timing | input | 2 | Trigger mode |
| cfg_irq_en | input | 1 | Raise channel interrupt at block end |
| cfg_req | input | 1 | Raise cartridge interrupt at block end (channel 3 only) |
| ctl_wr | input | 1 | Write strobe for the enable bit |
| ctl_en | input | 1 | Enable value written with `ctl_wr` |
| bus_rdata | input | 32 | Read data, valid in the read cycle |
| bus_rd | output | 1 | Read strobe |
| bus_wr | output | 1 | Write strobe |
| bus_idle | output | 1 | Idle-cycle strobe |
| bus_word | output | 1 | Access size, 1 = word |
| bus_seq | output | 1 | Sequential hint |
| bus_addr | output | ADDR_W | Aligned access address |
| bus_wdata | output | 32 | Write data |
| chan_enabled | output | 1 | Enable bit |
| chan_busy | output | 1 | Channel active |
| irq_vec | output | NUM_CH | Channel interrupt pulse vector |
| cart_irq | output | 1 | Cartridge interrupt pulse |

## Verification
The assertions watch every cycle for address alignment and for reads or writes below the protected bound. They also check for silence on the bus in the two clocks after activation, while halted at a unit boundary and while inactive, and that interrupt pulses last one clock. Whether the addresses step the right way, whether the target comes back at block end, where the sequential hint lands, whether the two-idle penalty is charged or waived, which trigger pulse actually starts the channel and whether the latched addresses ignore later changes only show up in the bench's scenarios. The bench compares the logged bus operation stream against values it computes from the configuration.

// File: rtl/dma_channel.sv
module dma_channel #(
  parameter int ADDR_W     = 28,
  parameter int CNT_W      = 14,
  parameter int CHAN_ID    = 3,
  parameter int NUM_CH     = 4,
  parameter int START_WAIT = 2,
  parameter int LOW_BOUND  = 32'h0200_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_halt,
  input  logic              vblank_pulse,
  input  logic              hblank_pulse,
  input  logic              line_req_pulse,
  input  logic [ADDR_W-1:0] cfg_src,
  input  logic [ADDR_W-1:0] cfg_dst,
  input  logic [CNT_W-1:0]  cfg_count,
  input  logic [1:0]        cfg_src_ctl,
  input  logic [1:0]        cfg_dst_ctl,
  input  logic              cfg_word,
  input  logic              cfg_repeat,
  input  logic [1:0]        cfg_timing,
  input  logic              cfg_irq_en,
  input  logic              cfg_req,
  input  logic              ctl_wr,
  input  logic              ctl_en,
  input  logic [31:0]       bus_rdata,
  output logic              bus_rd,
  output logic              bus_wr,
  output logic              bus_idle,
  output logic              bus_word,
  output logic              bus_seq,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [31:0]       bus_wdata,
  output logic              chan_enabled,
  output logic              chan_busy,
  output logic [NUM_CH-1:0] irq_vec,
  output logic              cart_irq
);

  localparam int WAIT_W = $clog2(START_WAIT + 1);
  localparam int CART_BIT = ADDR_W - 1;
  localparam logic [ADDR_W-1:0] BOUND = ADDR_W'(LOW_BOUND);
  localparam bit IS_CH3 = (CHAN_ID == 3);

  localparam logic [1:0] PH_HEAD = 2'd0;
  localparam logic [1:0] PH_PEN2 = 2'd1;
  localparam logic [1:0] PH_RD   = 2'd2;
  localparam logic [1:0] PH_WR   = 2'd3;

  logic              en_q, act_q, irq_q, cart_q;
  logic [WAIT_W-1:0] wait_q;
  logic [1:0]        ph_q;
  logic [ADDR_W-1:0] wsrc_q, wdst_q;
  logic [CNT_W-1:0]  wcnt_q;
  logic [31:0]       data_q;

  logic first, pen, go, rd_slot, wr_slot, pen_slot, src_low, dst_low;
  logic en_rise, trig, done;
  logic [ADDR_W-1:0] step, amask;
  logic [CNT_W-1:0]  cnt_dec;

  assign first    = (wcnt_q == cfg_count);
  assign pen      = first && !(wsrc_q[CART_BIT] && wdst_q[CART_BIT]);
  assign go       = act_q && (wait_q == '0) && !cpu_halt && (ph_q == PH_HEAD);
  assign rd_slot  = (go && !pen) || (ph_q == PH_RD);
  assign wr_slot  = (ph_q == PH_WR);
  assign pen_slot = (go && pen) || (ph_q == PH_PEN2);
  assign src_low  = wsrc_q < BOUND;
  assign dst_low  = wdst_q < BOUND;

  assign step  = cfg_word ? ADDR_W'(4) : ADDR_W'(2);
  assign amask = cfg_word ? ~ADDR_W'(3) : ~ADDR_W'(1);

  assign bus_rd    = rd_slot && !src_low;
  assign bus_wr    = wr_slot && !dst_low;
  assign bus_idle  = pen_slot || (rd_slot && src_low) || (wr_slot && dst_low);
  assign bus_word  = cfg_word;
  assign bus_seq   = (bus_rd || bus_wr) && !first;
  assign bus_addr  = bus_rd ? (wsrc_q & amask) : bus_wr ? (wdst_q & amask) : '0;
  assign bus_wdata = bus_wr ? data_q : 32'd0;

  assign en_rise = ctl_wr && ctl_en && !en_q;
  assign trig    = en_q && !act_q &&
                   ((cfg_timing == 2'd1 && vblank_pulse) ||
                    (cfg_timing == 2'd2 && hblank_pulse) ||
                    (cfg_timing == 2'd3 && line_req_pulse && IS_CH3));
  assign cnt_dec = wcnt_q - 1'b1;
  assign done    = wr_slot && (cnt_dec == '0);

  assign chan_enabled = en_q;
  assign chan_busy    = act_q;
  assign irq_vec      = NUM_CH'(irq_q) << CHAN_ID;
  assign cart_irq     = cart_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      act_q  <= 1'b0;
      wait_q <= '0;
      ph_q   <= PH_HEAD;
      wsrc_q <= '0;
      wdst_q <= '0;
      wcnt_q <= '0;
      data_q <= '0;
      irq_q  <= 1'b0;
      cart_q <= 1'b0;
    end else begin
      irq_q  <= done && cfg_irq_en;
      cart_q <= done && cfg_req && IS_CH3;
      if (ctl_wr && !ctl_en) begin
        en_q  <= 1'b0;
        act_q <= 1'b0;
        ph_q  <= PH_HEAD;
      end else if (en_rise) begin
        en_q   <= 1'b1;
        wsrc_q <= cfg_src;
        wdst_q <= cfg_dst;
        wcnt_q <= cfg_count;
        act_q  <= (cfg_timing == 2'd0);
        wait_q <= WAIT_W'(START_WAIT);
        ph_q   <= PH_HEAD;
      end else begin
        if (trig) begin
          act_q  <= 1'b1;
          wait_q <= WAIT_W'(START_WAIT);
        end
        if (act_q && wait_q != '0) wait_q <= wait_q - 1'b1;
        if (bus_rd) data_q <= bus_rdata;
        case (ph_q)
          PH_HEAD: if (go) ph_q <= pen ? PH_PEN2 : PH_WR;
          PH_PEN2: ph_q <= PH_RD;
          PH_RD:   ph_q <= PH_WR;
          default: begin
            ph_q   <= PH_HEAD;
            wcnt_q <= cnt_dec;
            case (cfg_src_ctl)
              2'd0:    wsrc_q <= wsrc_q + step;
              2'd1:    wsrc_q <= wsrc_q - step;
              default: wsrc_q <= wsrc_q;
            endcase
            case (cfg_dst_ctl)
              2'd1:    wdst_q <= wdst_q - step;
              2'd2:    wdst_q <= wdst_q;
              default: wdst_q <= wdst_q + step;
            endcase
            if (done) begin
              act_q <= 1'b0;
              if (cfg_dst_ctl == 2'd3) wdst_q <= cfg_dst;
              if (cfg_repeat) wcnt_q <= cfg_count;
              else en_q <= 1'b0;
            end
          end
        endcase
      end
    end
  end

  AST_ALIGN_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    ((bus_rd || bus_wr) && bus_word) |-> (bus_addr[1:0] == 2'b00)); // R2
  AST_ALIGN_HALF: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd || bus_wr) |-> (bus_addr[0] == 1'b0)); // R2
  AST_NO_LOW_READ: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |-> (bus_addr >= BOUND)); // R7
  AST_NO_LOW_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr |-> (bus_addr >= BOUND)); // R7
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({bus_rd, bus_wr, bus_idle})); // R7
  AST_START_QUIET0: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(act_q) |-> !(bus_rd || bus_wr || bus_idle)); // R8
  AST_START_QUIET1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(act_q) |=> !(bus_rd || bus_wr || bus_idle)); // R8
  AST_HALT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_halt && ph_q == PH_HEAD) |-> !(bus_rd || bus_wr || bus_idle)); // R9
  AST_QUIET_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !act_q |-> !(bus_rd || bus_wr || bus_idle)); // R11
  AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |=> !irq_q); // R12
  AST_CART_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    cart_q |=> !cart_q); // R12

endmodule

// File: tb/tb_dma_channel.sv
`timescale 1ns/1ps
module tb_dma_channel;
  localparam int AW = 28;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic cpu_halt = 0, vblank_pulse = 0, hblank_pulse = 0, line_req_pulse = 0;
  logic [AW-1:0] cfg_src = '0, cfg_dst = '0;
  logic [13:0] cfg_count = '0;
  logic [1:0] cfg_src_ctl = 0, cfg_dst_ctl = 0, cfg_timing = 0;
  logic cfg_word = 0, cfg_repeat = 0, cfg_irq_en = 0, cfg_req = 0;
  logic ctl_wr = 0, ctl_en = 0, c1_ctl_wr = 0;

  logic bus_rd, bus_wr, bus_idle, bus_word, bus_seq, chan_enabled, chan_busy, cart_irq;
  logic [AW-1:0] bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic [3:0] irq_vec;

  logic c1_rd, c1_wr, c1_idle, c1_word, c1_seq, c1_en, c1_busy, c1_cart;
  logic [AW-1:0] c1_addr;
  logic [31:0] c1_wdata, c1_rdata;
  logic [3:0] c1_irq;

  function automatic logic [31:0] memf(input logic [AW-1:0] a);
    return {a[15:0], ~a[15:0]};
  endfunction

  assign bus_rdata = memf(bus_addr);
  assign c1_rdata  = memf(c1_addr);

  dma_channel dut (
    .clk(clk), .rst_n(rst_n), .cpu_halt(cpu_halt), .vblank_pulse(vblank_pulse),
    .hblank_pulse(hblank_pulse), .line_req_pulse(line_req_pulse),
    .cfg_src(cfg_src), .cfg_dst(cfg_dst), .cfg_count(cfg_count),
    .cfg_src_ctl(cfg_src_ctl), .cfg_dst_ctl(cfg_dst_ctl), .cfg_word(cfg_word),
    .cfg_repeat(cfg_repeat), .cfg_timing(cfg_timing), .cfg_irq_en(cfg_irq_en),
    .cfg_req(cfg_req), .ctl_wr(ctl_wr), .ctl_en(ctl_en), .bus_rdata(bus_rdata),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_idle(bus_idle), .bus_word(bus_word),
    .bus_seq(bus_seq), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .chan_enabled(chan_enabled), .chan_busy(chan_busy), .irq_vec(irq_vec),
    .cart_irq(cart_irq));

  dma_channel #(.CHAN_ID(1)) dut_c1 (
    .clk(clk), .rst_n(rst_n), .cpu_halt(cpu_halt), .vblank_pulse(vblank_pulse),
    .hblank_pulse(hblank_pulse), .line_req_pulse(line_req_pulse),
    .cfg_src(cfg_src), .cfg_dst(cfg_dst), .cfg_count(cfg_count),
    .cfg_src_ctl(cfg_src_ctl), .cfg_dst_ctl(cfg_dst_ctl), .cfg_word(cfg_word),
    .cfg_repeat(cfg_repeat), .cfg_timing(cfg_timing), .cfg_irq_en(cfg_irq_en),
    .cfg_req(cfg_req), .ctl_wr(c1_ctl_wr), .ctl_en(ctl_en), .bus_rdata(c1_rdata),
    .bus_rd(c1_rd), .bus_wr(c1_wr), .bus_idle(c1_idle), .bus_word(c1_word),
    .bus_seq(c1_seq), .bus_addr(c1_addr), .bus_wdata(c1_wdata),
    .chan_enabled(c1_en), .chan_busy(c1_busy), .irq_vec(c1_irq),
    .cart_irq(c1_cart));

  // operation log: type 1 read, 2 write, 3 idle
  int n_ops = 0, cyc = 0, t_start = 0;
  int irq_n = 0, cart_n = 0, bad_bits = 0, c1_irq_n = 0, c1_cart_n = 0;
  logic [1:0]    op_t [0:255];
  logic          op_s [0:255];
  logic [AW-1:0] op_a [0:255];
  logic [31:0]   op_d [0:255];
  int            op_c [0:255];

  always @(posedge clk) begin
    if (rst_n) begin
      if ((bus_rd || bus_wr || bus_idle) && n_ops < 256) begin
        op_t[n_ops] = bus_rd ? 2'd1 : bus_wr ? 2'd2 : 2'd3;
        op_s[n_ops] = bus_seq;
        op_a[n_ops] = bus_addr;
        op_d[n_ops] = bus_wdata;
        op_c[n_ops] = cyc;
        n_ops = n_ops + 1;
      end
      if (ctl_wr && ctl_en) t_start = cyc;
      if (irq_vec[3]) irq_n = irq_n + 1;
      if (irq_vec[2:0] != 3'd0) bad_bits = bad_bits + 1;
      if (cart_irq) cart_n = cart_n + 1;
      if (c1_irq[1]) c1_irq_n = c1_irq_n + 1;
      if (c1_irq[3] || c1_irq[2] || c1_irq[0]) bad_bits = bad_bits + 1;
      if (c1_cart) c1_cart_n = c1_cart_n + 1;
    end
    cyc = cyc + 1;
  end

  int tests = 0, fails = 0;
  bit finished = 0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic chk_op(input string tag, input int i, input logic [1:0] t,
                        input logic s, input logic [AW-1:0] a, input logic [31:0] d);
    chk(tag, {2'(op_t[i]), 1'(op_s[i]), op_a[i], op_d[i]}, {t, s, a, d});
  endtask

  task automatic setup(input logic [AW-1:0] s, input logic [AW-1:0] d, input logic [13:0] n,
                       input logic [1:0] sc, input logic [1:0] dc, input logic w,
                       input logic rep, input logic [1:0] tm, input logic ie, input logic rq);
    @(negedge clk);
    cfg_src = s; cfg_dst = d; cfg_count = n; cfg_src_ctl = sc; cfg_dst_ctl = dc;
    cfg_word = w; cfg_repeat = rep; cfg_timing = tm; cfg_irq_en = ie; cfg_req = rq;
  endtask

  task automatic write_en(input logic v);
    @(negedge clk); ctl_wr = 1; ctl_en = v;
    @(negedge clk); ctl_wr = 0; ctl_en = 0;
  endtask

  task automatic write_en_c1(input logic v);
    @(negedge clk); c1_ctl_wr = 1; ctl_en = v;
    @(negedge clk); c1_ctl_wr = 0; ctl_en = 0;
  endtask

  task automatic idle_cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic test_reset();
    chk("R11 reset enable", chan_enabled, 0);
    chk("R11 reset busy", chan_busy, 0);
    chk("R12 reset irq", {irq_vec, cart_irq}, 0);
    chk("R8 no ops after reset", n_ops, 0);
  endtask

  task automatic test_word_inc();
    int b = n_ops, i0 = irq_n;
    setup(28'h300_0000, 28'h300_1000, 14'd3, 2'd0, 2'd0, 1, 0, 2'd0, 1, 0);
    write_en(1);
    idle_cycles(20);
    chk("R1 word op count", n_ops - b, 8);
    chk_op("R6 penalty idle 0", b, 3, 0, 0, 0);
    chk_op("R6 penalty idle 1", b + 1, 3, 0, 0, 0);
    chk_op("R5 first read nonseq", b + 2, 1, 0, 28'h300_0000, 0);
    chk_op("R5 first write nonseq", b + 3, 2, 0, 28'h300_1000, memf(28'h300_0000));
    chk_op("R1 R3 second read", b + 4, 1, 1, 28'h300_0004, 0);
    chk_op("R4 second write", b + 5, 2, 1, 28'h300_1004, memf(28'h300_0004));
    chk_op("R3 third read", b + 6, 1, 1, 28'h300_0008, 0);
    chk_op("R4 third write", b + 7, 2, 1, 28'h300_1008, memf(28'h300_0008));
    chk("R8 first op cycle", op_c[b], t_start + 3);
    chk("R8 back to back", op_c[b + 7], t_start + 10);
    chk("R12 one irq pulse", irq_n - i0, 1);
    chk("R11 enable cleared", chan_enabled, 0);
    chk("R11 inactive", chan_busy, 0);
  endtask

  task automatic test_half_dec();
    int b = n_ops;
    setup(28'h300_0003, 28'h200_0001, 14'd2, 2'd1, 2'd2, 0, 0, 2'd0, 0, 0);
    write_en(1);
    idle_cycles(16);
    chk("R1 half op count", n_ops - b, 6);
    chk_op("R2 R1 half read aligned", b + 2, 1, 0, 28'h300_0002, 0);
    chk_op("R2 R4 half write fixed", b + 3, 2, 0, 28'h200_0000, memf(28'h300_0002));
    chk_op("R3 decrement by 2", b + 4, 1, 1, 28'h300_0000, 0);
    chk_op("R4 fixed target", b + 5, 2, 1, 28'h200_0000, memf(28'h300_0000));
  endtask

  task automatic test_cart_repeat();
    int b = n_ops, i0 = irq_n;
    setup(28'h800_0010, 28'h800_2000, 14'd2, 2'd2, 2'd3, 1, 1, 2'd1, 1, 0);
    write_en(1);
    idle_cycles(6);
    chk("R10 waits for vblank", n_ops - b, 0);
    @(negedge clk); hblank_pulse = 1; @(negedge clk); hblank_pulse = 0;
    idle_cycles(6);
    chk("R10 hblank ignored in mode 1", n_ops - b, 0);
    @(negedge clk); vblank_pulse = 1; @(negedge clk); vblank_pulse = 0;
    idle_cycles(12);
    chk("R6 no penalty in cart space", n_ops - b, 4);
    chk_op("R6 read first", b, 1, 0, 28'h800_0010, 0);
    chk_op("R3 fixed source", b + 2, 1, 1, 28'h800_0010, 0);
    chk_op("R4 mode 3 increments", b + 3, 2, 1, 28'h800_2004, memf(28'h800_0010));
    chk("R11 repeat keeps enable", chan_enabled, 1);
    chk("R11 inactive after block", chan_busy, 0);
    @(negedge clk); vblank_pulse = 1; @(negedge clk); vblank_pulse = 0;
    idle_cycles(12);
    chk("R11 repeat reload count", n_ops - b, 8);
    chk_op("R4 target restored", b + 5, 2, 0, 28'h800_2000, memf(28'h800_0010));
    chk("R12 irq per block", irq_n - i0, 2);
    write_en(0);
    chk("R11 disabled", chan_enabled, 0);
  endtask

  task automatic test_protected();
    int b = n_ops;
    setup(28'h100_0000, 28'h000_0010, 14'd1, 2'd0, 2'd0, 1, 0, 2'd0, 0, 0);
    write_en(1);
    idle_cycles(10);
    chk("R7 four idles", n_ops - b, 4);
    chk_op("R7 read replaced", b + 2, 3, 0, 0, 0);
    chk_op("R7 write replaced", b + 3, 3, 0, 0, 0);
    b = n_ops;
    setup(28'h000_0100, 28'h300_0040, 14'd1, 2'd0, 2'd0, 1, 0, 2'd0, 0, 0);
    write_en(1);
    idle_cycles(10);
    chk_op("R7 idle read", b + 2, 3, 0, 0, 0);
    chk_op("R7 stale data written", b + 3, 2, 0, 28'h300_0040, memf(28'h800_0010));
  endtask

  task automatic test_halt();
    int b = n_ops;
    setup(28'h300_0100, 28'h300_0200, 14'd2, 2'd0, 2'd0, 1, 0, 2'd0, 0, 0);
    @(negedge clk); cpu_halt = 1;
    write_en(1);
    idle_cycles(10);
    chk("R9 no ops while halted", n_ops - b, 0);
    chk("R9 busy while halted", chan_busy, 1);
    @(negedge clk); cpu_halt = 0;
    @(negedge clk);
    chk("R9 resumes at once", n_ops - b, 1);
    idle_cycles(10);
    chk("R9 block completes", n_ops - b, 6);
    chk_op("R9 last write", b + 5, 2, 1, 28'h300_0204, memf(28'h300_0104));
  endtask

  task automatic test_triggers();
    int b = n_ops, k0 = cart_n, c0 = c1_irq_n, cc0 = c1_cart_n;
    setup(28'h800_0000, 28'h800_0100, 14'd1, 2'd0, 2'd0, 1, 0, 2'd2, 0, 1);
    write_en(1);
    @(negedge clk); vblank_pulse = 1; @(negedge clk); vblank_pulse = 0;
    idle_cycles(6);
    chk("R10 vblank ignored in mode 2", {chan_busy, 8'(n_ops - b)}, 0);
    @(negedge clk); hblank_pulse = 1; @(negedge clk); hblank_pulse = 0;
    idle_cycles(8);
    chk("R10 hblank starts mode 2", n_ops - b, 2);
    chk("R12 cart irq on channel 3", cart_n - k0, 1);
    b = n_ops;
    setup(28'h800_0000, 28'h800_0100, 14'd1, 2'd0, 2'd0, 1, 0, 2'd3, 0, 1);
    write_en(1);
    write_en_c1(1);
    @(negedge clk); line_req_pulse = 1; @(negedge clk); line_req_pulse = 0;
    @(negedge clk);
    chk("R10 line request ignored off channel 3", c1_busy, 0);
    idle_cycles(8);
    chk("R10 line request starts channel 3", n_ops - b, 2);
    write_en_c1(0);
    setup(28'h800_0000, 28'h800_0100, 14'd1, 2'd0, 2'd0, 1, 0, 2'd0, 1, 1);
    write_en_c1(1);
    idle_cycles(8);
    chk("R12 channel 1 irq bit", c1_irq_n - c0, 1);
    chk("R12 no cart irq off channel 3", c1_cart_n - cc0, 0);
    chk("R12 no stray irq bits", bad_bits, 0);
  endtask

  task automatic test_latch();
    int b = n_ops;
    setup(28'h300_0300, 28'h300_0400, 14'd1, 2'd0, 2'd0, 1, 0, 2'd1, 0, 0);
    write_en(1);
    @(negedge clk); cfg_src = 28'h300_0500; cfg_dst = 28'h300_0600;
    @(negedge clk); vblank_pulse = 1; @(negedge clk); vblank_pulse = 0;
    idle_cycles(8);
    chk_op("R13 latched source", b + 2, 1, 0, 28'h300_0300, 0);
    chk_op("R13 latched target", b + 3, 2, 0, 28'h300_0400, memf(28'h300_0300));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    idle_cycles(2);
    test_reset();
    test_word_inc();
    test_half_dec();
    test_cart_repeat();
    test_protected();
    test_halt();
    test_triggers();
    test_latch();
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #200000;
    if (!finished) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule